// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block produces the reset for every clock domain of a design whose clocks come from a PLL. A free-running reference clock drives a small power-up sequencer. The sequencer first passes the PLL lock indication through a two-flop synchronizer. It then lets a saturating counter advance only while that synchronized lock is high. The power-up reset that the counter produces is ORed with three other sources into one master reset: a hardware reset pin, a software reset request, and a parameterised set of reset requests fed back from user modules.

The master reset is handed to one reset bridge per output clock domain. Each bridge asserts its domain reset at once, without waiting for a clock edge. It releases the reset only after two rising edges of that domain's own clock. The hardware reset input is also routed straight to the PLL reset output. That path never depends on any clock the PLL produces, so the design cannot wait forever on a clock that is held in reset.

Top module: `rstseq_top`

## Requirements
- R1: While the synchronized lock is low, the power-up counter stays where it is. Every domain reset remains high as long as `pll_locked_i` has been low since power-up.
- R2: When `pll_locked_i` rises and stays high, a domain clocked by the reference clock releases its reset at the 8th rising reference edge after the rise. The 8 edges are made up of 2 for lock synchronization, 3 counter steps from 0 to 3, 1 for the registered power-up flag, and 2 for the domain bridge.
- R3: The power-up counter saturates at 3 and holds that value. A loss of lock after release reasserts no reset. A later hardware reset releases through the domain bridges alone, without a new power-up count.
- R4: A high level on `hw_rst_i`, on `soft_rst_i` or on any bit of `fb_rst_i` drives every `dom_rst_o` bit high within the same cycle, with no clock edge needed.
- R5: Once all sources are low, `dom_rst_o[k]` stays high through the first rising edge of `dom_clk_i[k]` and falls at the second. A domain whose clock does not run stays in reset.
- R6: `pll_rst_o` equals `hw_rst_i` at all times, including while lock is low and before the power-up release.
- R7: The power-up counter and its lock synchronizer have no reset input of any kind. Their power-up value is count 0, with the power-up reset flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Free-running reference clock for the lock synchronizer and power-up counter |
| pll_locked_i | input | 1 | PLL lock indication, asynchronous |
| hw_rst_i | input | 1 | Hardware reset, active high, asynchronous |
| soft_rst_i | input | 1 | Software reset request, active high |
| fb_rst_i | input | NUM_FB | Reset requests fed back from user modules, active high |
| dom_clk_i | input | NUM_DOM | One clock per output domain |
| dom_rst_o | output | NUM_DOM | Per-domain reset, active high, asynchronous assert, synchronous release |
| pll_rst_o | output | 1 | Reset to the PLL, driven from the hardware reset |

## Verification
The bench builds the block with NUM_DOM = 3 and NUM_FB = 2. Domain 0 is clocked by the reference clock, so its release edge can be counted exactly against the power-up sequence. Domain 1 runs on an unrelated slower clock. Domain 2 is left without a clock until the end, which shows that assertion needs no edge while release needs two edges of the domain's own clock. Two feedback inputs are enough to show that each bit alone, and both together, reach every domain.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Count value at which the power-up sequencer releases its reset.
    localparam int unsigned POR_LIMIT = 3;
    localparam int unsigned POR_CW    = $clog2(POR_LIMIT + 1);

    typedef struct packed {
        logic [POR_CW-1:0] cnt;
        logic              por;
    } por_state_t;

    typedef struct packed {
        logic meta;
        logic out;
    } bridge_state_t;

endpackage

// File: rtl/rstseq_lock_sync.sv
module rstseq_lock_sync (
    input  logic clk_i,
    input  logic async_i,
    output logic sync_o
);
    // Two-stage level synchronizer. It has no reset: the stages come up low.
    logic s1_d, s2_d;
    logic s1_q = 1'b0;
    logic s2_q = 1'b0;

    always_comb begin
        s1_d = async_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk_i) begin
        s1_q <= s1_d;
        s2_q <= s2_d;
    end

    assign sync_o = s2_q;

    // R1: the output only follows what the first stage held one edge earlier
    a_r1_two_stage: assert property (@(posedge clk_i)
        1'b1 |=> (s2_q == $past(s1_q)));
endmodule

// File: rtl/rstseq_por_counter.sv
module rstseq_por_counter
    import rstseq_pkg::*;
(
    input  logic clk_i,
    input  logic lock_sync_i,
    output logic por_o
);
    // R7: the state has no reset input. Its power-up value is set here.
    por_state_t state_d;
    por_state_t state_q = '{cnt: '0, por: 1'b1};

    always_comb begin
        state_d = state_q;
        if (lock_sync_i) begin
            if (state_q.cnt < POR_CW'(POR_LIMIT))
                state_d.cnt = state_q.cnt + 1'b1;
            state_d.por = (state_q.cnt != POR_CW'(POR_LIMIT));
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign por_o = state_q.por;

    // R3: once the count has reached the limit, it stays there
    a_r3_saturate: assert property (@(posedge clk_i)
        (state_q.cnt == POR_CW'(POR_LIMIT)) |=> (state_q.cnt == POR_CW'(POR_LIMIT)));

    // R1: without synchronized lock, nothing moves
    a_r1_hold_unlocked: assert property (@(posedge clk_i)
        !lock_sync_i |=> ($stable(state_q.cnt) && $stable(state_q.por)));

    // R3: a released power-up reset implies the count is complete
    a_r3_release_done: assert property (@(posedge clk_i)
        !state_q.por |-> (state_q.cnt == POR_CW'(POR_LIMIT)));

    // R3: once released, the power-up reset never comes back
    a_r3_no_reassert: assert property (@(posedge clk_i)
        !state_q.por |=> !state_q.por);
endmodule

// File: rtl/rstseq_dom_bridge.sv
module rstseq_dom_bridge
    import rstseq_pkg::*;
(
    input  logic clk_i,
    input  logic arst_i,
    output logic rst_o
);
    // The bridge asserts asynchronously and releases after two edges of clk_i.
    bridge_state_t br_d;
    bridge_state_t br_q = '{meta: 1'b1, out: 1'b1};

    always_comb begin
        br_d.meta = 1'b0;
        br_d.out  = br_q.meta;
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i)
            br_q <= '{meta: 1'b1, out: 1'b1};
        else
            br_q <= br_d;
    end

    assign rst_o = br_q.out;

    // R4: while the master reset is high, the domain is held in reset
    a_r4_held: assert property (@(posedge clk_i)
        arst_i |-> rst_o);

    // R5: a release happens only after the master reset was low across an edge
    a_r5_release: assert property (@(posedge clk_i)
        $fell(rst_o) |-> (!arst_i && !$past(arst_i)));
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
    parameter int unsigned NUM_DOM = 3,
    parameter int unsigned NUM_FB  = 2
) (
    input  logic               ref_clk_i,
    input  logic               pll_locked_i,
    input  logic               hw_rst_i,
    input  logic               soft_rst_i,
    input  logic [NUM_FB-1:0]  fb_rst_i,
    input  logic [NUM_DOM-1:0] dom_clk_i,
    output logic [NUM_DOM-1:0] dom_rst_o,
    output logic               pll_rst_o
);
    logic lock_sync;
    logic por_rst;
    logic fb_any;
    logic master_rst;

    rstseq_lock_sync u_lock_sync (
        .clk_i   (ref_clk_i),
        .async_i (pll_locked_i),
        .sync_o  (lock_sync)
    );

    rstseq_por_counter u_por (
        .clk_i       (ref_clk_i),
        .lock_sync_i (lock_sync),
        .por_o       (por_rst)
    );

    assign fb_any     = |fb_rst_i;
    assign master_rst = por_rst | fb_any | soft_rst_i | hw_rst_i;

    // R6: the PLL reset is taken from the pin alone and uses no PLL clock
    assign pll_rst_o = hw_rst_i;

    for (genvar k = 0; k < NUM_DOM; k++) begin : g_dom
        rstseq_dom_bridge u_bridge (
            .clk_i  (dom_clk_i[k]),
            .arst_i (master_rst),
            .rst_o  (dom_rst_o[k])
        );
    end

    // R4: any external source holds every domain in reset
    a_r4_all_domains: assert property (@(posedge ref_clk_i)
        (hw_rst_i || soft_rst_i || fb_any) |-> (&dom_rst_o));

    // R1: no domain leaves reset before the sequencer has released
    a_r1_por_gate: assert property (@(posedge ref_clk_i)
        por_rst |-> (&dom_rst_o));
endmodule

// File: tb/rstseq_top_tb_top.sv
module rstseq_top_tb_top;
    localparam int NUM_DOM = 3;
    localparam int NUM_FB  = 2;

    logic ref_clk = 1'b0;
    logic dclk1   = 1'b0;
    logic dclk2   = 1'b0;
    logic pll_locked = 1'b0;
    logic hw_rst     = 1'b0;
    logic soft_rst   = 1'b0;
    logic [NUM_FB-1:0]  fb_rst = '0;
    logic [NUM_DOM-1:0] dom_clk;
    logic [NUM_DOM-1:0] dom_rst;
    logic pll_rst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 ref_clk = ~ref_clk;   // 50 MHz
    always #17 dclk1   = ~dclk1;

    assign dom_clk = {dclk2, dclk1, ref_clk};

    rstseq_top #(.NUM_DOM(NUM_DOM), .NUM_FB(NUM_FB)) dut_i (
        .ref_clk_i    (ref_clk),
        .pll_locked_i (pll_locked),
        .hw_rst_i     (hw_rst),
        .soft_rst_i   (soft_rst),
        .fb_rst_i     (fb_rst),
        .dom_clk_i    (dom_clk),
        .dom_rst_o    (dom_rst),
        .pll_rst_o    (pll_rst)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // {hw, soft, fb[1], fb[0], any-source}
    localparam logic [4:0] VEC [8] = '{
        5'b00000, 5'b10001, 5'b01001, 5'b00011,
        5'b00101, 5'b00111, 5'b11111, 5'b00000
    };

    initial begin
        // Reset state and behaviour while unlocked
        @(negedge ref_clk);
        chk("R7 power-up dom0", dom_rst[0], 1'b1);
        chk("R7 power-up dom2", dom_rst[2], 1'b1);
        chk("R6 pll_rst idle", pll_rst, 1'b0);
        repeat (10) @(negedge ref_clk);
        chk("R1 unlocked dom0", dom_rst[0], 1'b1);
        chk("R1 unlocked dom1", dom_rst[1], 1'b1);
        hw_rst = 1'b1;
        #2;
        chk("R6 pll_rst follows hw while unlocked", pll_rst, 1'b1);
        @(negedge ref_clk);
        hw_rst = 1'b0;
        #2;
        chk("R6 pll_rst clears", pll_rst, 1'b0);

        // Power-up release: dom0 falls at the 8th rising edge
        @(negedge ref_clk);
        pll_locked = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(posedge ref_clk);
            @(negedge ref_clk);
            chk("R2 release edge dom0", dom_rst[0], (k < 8) ? 1'b1 : 1'b0);
        end
        repeat (4) @(negedge ref_clk);
        chk("R2 release dom1", dom_rst[1], 1'b0);
        chk("R5 unclocked dom2 held", dom_rst[2], 1'b1);

        // Source table
        for (int i = 0; i < 8; i++) begin
            logic [4:0] v;
            v = VEC[i];
            @(negedge ref_clk);
            hw_rst   = v[4];
            soft_rst = v[3];
            fb_rst   = v[2:1];
            #2;
            chk("R4 async assert dom0", dom_rst[0], v[0]);
            chk("R4 async assert dom1", dom_rst[1], v[0]);
            chk("R6 pll_rst equals hw", pll_rst, v[4]);
            @(negedge ref_clk);
            hw_rst = 1'b0; soft_rst = 1'b0; fb_rst = '0;
            @(posedge ref_clk);
            @(negedge ref_clk);
            chk("R5 held one edge", dom_rst[0], v[0]);
            @(posedge ref_clk);
            @(negedge ref_clk);
            chk("R5 released second edge", dom_rst[0], 1'b0);
            repeat (4) @(negedge ref_clk);
            chk("R5 dom1 released", dom_rst[1], 1'b0);
        end

        // Lock loss after release
        pll_locked = 1'b0;
        repeat (12) @(negedge ref_clk);
        chk("R3 lock loss dom0", dom_rst[0], 1'b0);
        chk("R3 lock loss dom1", dom_rst[1], 1'b0);

        // Hardware reset while unlocked: fresh reset, release with no new count
        hw_rst = 1'b1;
        #2;
        chk("R4 hw reset dom0", dom_rst[0], 1'b1);
        chk("R6 pll_rst unlocked", pll_rst, 1'b1);
        @(negedge ref_clk);
        hw_rst = 1'b0;
        @(posedge ref_clk);
        @(negedge ref_clk);
        chk("R3 held after hw", dom_rst[0], 1'b1);
        @(posedge ref_clk);
        @(negedge ref_clk);
        chk("R3 counter kept saturation", dom_rst[0], 1'b0);

        // Unclocked domain releases only on its own two edges
        chk("R5 dom2 before clocking", dom_rst[2], 1'b1);
        #5 dclk2 = 1'b1; #5 dclk2 = 1'b0;
        #1;
        chk("R5 dom2 after one edge", dom_rst[2], 1'b1);
        #5 dclk2 = 1'b1; #5 dclk2 = 1'b0;
        #1;
        chk("R5 dom2 after two edges", dom_rst[2], 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge ref_clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule